// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block keeps the lane-enable mask and the redirect PC for one warp of threads that share one instruction sequencer. When a conditional branch is resolved, the block is given a per-lane taken mask, the taken target, the fall-through address and the reconvergence address. The reconvergence address is the immediate post-dominator of the branch block, and the compiler supplies it with the branch. If every enabled lane goes the same way, the block only redirects the PC. If the enabled lanes split, the block runs the taken lanes first, then the not-taken lanes, and then restores the merged mask once the fetch reaches the reconvergence address.

The state is a stack of records. Each record holds a reconvergence PC, a resume PC and a lane mask. The top record drives `activeMask` and `nextPc`. When the branch splits, the current top has its resume PC replaced by the reconvergence PC. Two records are then pushed: the not-taken record first and the taken record above it. Whenever the fetch PC equals the top record's reconvergence PC, that record is discarded. Nested branches stack further records, up to a depth that is set by a parameter.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, `activeMask` is all ones, `nextPc` equals the parameter `RESET_PC`, `ovfErr` is 0, and the stack holds a single record.
- R2: A branch in which every enabled lane has its taken bit set leaves `activeMask` unchanged and sets `nextPc` to `brTargetPc` on the following cycle.
- R3: A branch in which no enabled lane has its taken bit set leaves `activeMask` unchanged and sets `nextPc` to `brFallPc` on the following cycle.
- R4: Taken bits of lanes that are currently disabled are ignored. Each taken bit is ANDed with the enable mask before the branch is classified.
- R5: A branch whose enabled lanes split makes `activeMask` equal to (taken AND enabled) and `nextPc` equal to `brTargetPc` on the next cycle. Below that record it leaves a record of the not-taken lanes that resumes at `brFallPc`, and under that a record that resumes at `brReconvPc`.
- R6: When `fetchValid` is 1, more than one record is held, and `fetchPc` equals the top record's reconvergence PC, the top record is discarded. The record beneath then drives `activeMask` and `nextPc` on the next cycle. At most one record is discarded per cycle.
- R7: A fetch whose PC matches while only the bottom record is held, or a cycle with `fetchValid` at 0 and no branch, changes neither `activeMask` nor `nextPc`.
- R8: Nested splits are undone innermost first. The inner paths merge at the inner reconvergence PC before the outer not-taken path runs.
- R9: A split that would need more than `DEPTH` records changes neither `activeMask` nor `nextPc`. It sets `ovfErr`, which stays at 1 until reset.
- R10: When a discard and a branch fall in the same cycle, the discard is applied first. The branch is then classified and applied against the record that the discard uncovered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brValid | input | 1 | A resolved branch is presented this cycle |
| brTakenMask | input | LANES | Per-lane branch outcome, bit i = lane i took the branch |
| brTargetPc | input | PC_W | Taken target address |
| brFallPc | input | PC_W | Fall-through address |
| brReconvPc | input | PC_W | Reconvergence address (immediate post-dominator) |
| fetchValid | input | 1 | `fetchPc` holds a fetch this cycle |
| fetchPc | input | PC_W | Address currently being fetched |
| activeMask | output | LANES | Lanes enabled for the current path |
| nextPc | output | PC_W | Address the sequencer should fetch next |
| ovfErr | output | 1 | Sticky stack overflow flag |

## Verification
The discard of a merged record and a new branch can fall in the same cycle. This happens when the branch instruction sits at the reconvergence address. The bench provokes it by presenting a fetch that matches the top record's reconvergence PC together with a branch whose taken mask splits the lanes of the uncovered not-taken record. It judges the result by the new mask, which must be drawn from the uncovered record and not from the discarded one. It then unwinds both levels and checks that each merge restores the expected mask and PC.

// File: rtl/reconv_pkg.sv
package reconv_pkg;

  typedef enum logic [1:0] {
    PC_KEEP   = 2'd0,
    PC_TARGET = 2'd1,
    PC_FALL   = 2'd2,
    PC_RECONV = 2'd3
  } pcSel_e;

  typedef struct packed {
    logic   doPop;
    pcSel_e pcSel;
    logic   pushPair;
  } stackCtrl_t;

endpackage

// File: rtl/reconv_ctrl.sv
module reconv_ctrl
  import reconv_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brValid,
  input  logic [LANES-1:0] brTakenMask,
  input  logic             fetchValid,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [PC_W-1:0]  topRpc,
  input  logic [LANES-1:0] topMask,
  input  logic [LANES-1:0] belowMask,
  output stackCtrl_t       ctrl,
  output logic [IW-1:0]    sp,
  output logic [IW-1:0]    baseIdx,
  output logic             ovfErr
);

  logic             popReq;
  logic [LANES-1:0] baseMask;
  logic [LANES-1:0] tkMask;
  logic [LANES-1:0] ntMask;
  logic             roomForPair;
  logic             ovfHit;
  logic [IW-1:0]    spNext;

  assign popReq      = fetchValid && (sp != '0) && (fetchPc == topRpc);
  assign baseIdx     = popReq ? sp - IW'(1) : sp;
  assign baseMask    = popReq ? belowMask : topMask;
  assign tkMask      = brTakenMask & baseMask;
  assign ntMask      = ~brTakenMask & baseMask;
  assign roomForPair = (int'(baseIdx) + 2) <= (DEPTH - 1);

  always_comb begin
    ctrl.doPop    = popReq;
    ctrl.pcSel    = PC_KEEP;
    ctrl.pushPair = 1'b0;
    ovfHit        = 1'b0;
    spNext        = baseIdx;
    if (brValid) begin
      if (tkMask == '0) begin
        ctrl.pcSel = PC_FALL;
      end else if (ntMask == '0) begin
        ctrl.pcSel = PC_TARGET;
      end else if (roomForPair) begin
        ctrl.pcSel    = PC_RECONV;
        ctrl.pushPair = 1'b1;
        spNext        = baseIdx + IW'(2);
      end else begin
        ovfHit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp     <= '0;
      ovfErr <= 1'b0;
    end else begin
      sp <= spNext;
      if (ovfHit) ovfErr <= 1'b1;
    end
  end

endmodule

// File: rtl/reconv_store.sv
module reconv_store
  import reconv_pkg::*;
#(
  parameter int              LANES    = 32,
  parameter int              PC_W     = 32,
  parameter int              DEPTH    = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int             IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackCtrl_t       ctrl,
  input  logic [IW-1:0]    sp,
  input  logic [IW-1:0]    baseIdx,
  input  logic [LANES-1:0] brTakenMask,
  input  logic [PC_W-1:0]  brTargetPc,
  input  logic [PC_W-1:0]  brFallPc,
  input  logic [PC_W-1:0]  brReconvPc,
  output logic [PC_W-1:0]  topRpc,
  output logic [PC_W-1:0]  topPc,
  output logic [LANES-1:0] topMask,
  output logic [LANES-1:0] belowMask
);

  logic [PC_W-1:0]  rpcArr  [DEPTH];
  logic [PC_W-1:0]  pcArr   [DEPTH];
  logic [LANES-1:0] maskArr [DEPTH];

  logic [IW-1:0]    belowIdx;
  logic [LANES-1:0] baseMask;
  logic [LANES-1:0] tkMask;
  logic [LANES-1:0] ntMask;
  logic [IW-1:0]    ntIdx;
  logic [IW-1:0]    tkIdx;

  assign belowIdx  = (sp == '0) ? '0 : sp - IW'(1);
  assign topRpc    = rpcArr[sp];
  assign topPc     = pcArr[sp];
  assign topMask   = maskArr[sp];
  assign belowMask = maskArr[belowIdx];

  assign baseMask = maskArr[baseIdx];
  assign tkMask   = brTakenMask & baseMask;
  assign ntMask   = ~brTakenMask & baseMask;
  assign ntIdx    = baseIdx + IW'(1);
  assign tkIdx    = baseIdx + IW'(2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        rpcArr[i]  <= '1;
        pcArr[i]   <= '0;
        maskArr[i] <= '0;
      end
      pcArr[0]   <= RESET_PC;
      maskArr[0] <= '1;
    end else begin
      unique case (ctrl.pcSel)
        PC_TARGET: pcArr[baseIdx] <= brTargetPc;
        PC_FALL:   pcArr[baseIdx] <= brFallPc;
        PC_RECONV: pcArr[baseIdx] <= brReconvPc;
        default:   ;
      endcase
      if (ctrl.pushPair) begin
        rpcArr[ntIdx]  <= brReconvPc;
        pcArr[ntIdx]   <= brFallPc;
        maskArr[ntIdx] <= ntMask;
        rpcArr[tkIdx]  <= brReconvPc;
        pcArr[tkIdx]   <= brTargetPc;
        maskArr[tkIdx] <= tkMask;
      end
    end
  end

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import reconv_pkg::*;
#(
  parameter int              LANES    = 32,
  parameter int              PC_W     = 32,
  parameter int              DEPTH    = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int             IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brValid,
  input  logic [LANES-1:0] brTakenMask,
  input  logic [PC_W-1:0]  brTargetPc,
  input  logic [PC_W-1:0]  brFallPc,
  input  logic [PC_W-1:0]  brReconvPc,
  input  logic             fetchValid,
  input  logic [PC_W-1:0]  fetchPc,
  output logic [LANES-1:0] activeMask,
  output logic [PC_W-1:0]  nextPc,
  output logic             ovfErr
);

  stackCtrl_t       ctrl;
  logic [IW-1:0]    sp;
  logic [IW-1:0]    baseIdx;
  logic [PC_W-1:0]  topRpc;
  logic [LANES-1:0] topMask;
  logic [LANES-1:0] belowMask;

  reconv_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .brValid(brValid), .brTakenMask(brTakenMask),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .topRpc(topRpc),
    .topMask(topMask), .belowMask(belowMask), .ctrl(ctrl), .sp(sp),
    .baseIdx(baseIdx), .ovfErr(ovfErr)
  );

  reconv_store #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(RESET_PC)) uStore (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sp(sp), .baseIdx(baseIdx),
    .brTakenMask(brTakenMask), .brTargetPc(brTargetPc), .brFallPc(brFallPc),
    .brReconvPc(brReconvPc), .topRpc(topRpc), .topPc(nextPc),
    .topMask(topMask), .belowMask(belowMask)
  );

  assign activeMask = topMask;

endmodule

// File: rtl/reconv_stack_chk.sv
module reconv_stack_chk #(
  parameter int LANES = 32,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             brValid,
  input logic [LANES-1:0] brTakenMask,
  input logic [PC_W-1:0]  brTargetPc,
  input logic [PC_W-1:0]  brFallPc,
  input logic             fetchValid,
  input logic [LANES-1:0] activeMask,
  input logic [PC_W-1:0]  nextPc,
  input logic             ovfErr
);

  // R2
  uniform_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !fetchValid && ((brTakenMask & activeMask) == activeMask))
    |=> (activeMask == $past(activeMask)) && (nextPc == $past(brTargetPc)));

  // R3
  uniform_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !fetchValid && ((brTakenMask & activeMask) == '0))
    |=> (activeMask == $past(activeMask)) && (nextPc == $past(brFallPc)));

  // R5
  split_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !fetchValid && ((brTakenMask & activeMask) != '0)
     && ((brTakenMask & activeMask) != activeMask))
    |=> (activeMask == $past(brTakenMask & activeMask)) || ovfErr);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!brValid && !fetchValid) |=> ($stable(activeMask) && $stable(nextPc)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr);

  // R5
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeMask != '0);

endmodule

bind simt_reconv_stack reconv_stack_chk #(.LANES(LANES), .PC_W(PC_W)) uChk (
  .clk(clk), .rstN(rstN), .brValid(brValid), .brTakenMask(brTakenMask),
  .brTargetPc(brTargetPc), .brFallPc(brFallPc), .fetchValid(fetchValid),
  .activeMask(activeMask), .nextPc(nextPc), .ovfErr(ovfErr)
);

// File: tb/sim_simt_reconv_stack.sv
`timescale 1ns/1ps
module sim_simt_reconv_stack;

  localparam logic [31:0] RST_PC = 32'h0000_0100;
  localparam logic [31:0] ALL    = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN;
  logic        brValid;
  logic [31:0] brTakenMask, brTargetPc, brFallPc, brReconvPc;
  logic        fetchValid;
  logic [31:0] fetchPc;
  logic [31:0] activeMask, nextPc;
  logic        ovfErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  simt_reconv_stack #(.LANES(32), .PC_W(32), .DEPTH(8), .RESET_PC(RST_PC)) u0 (
    .clk(clk), .rstN(rstN), .brValid(brValid), .brTakenMask(brTakenMask),
    .brTargetPc(brTargetPc), .brFallPc(brFallPc), .brReconvPc(brReconvPc),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .activeMask(activeMask),
    .nextPc(nextPc), .ovfErr(ovfErr)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clearIn();
    brValid = 0; brTakenMask = 0; brTargetPc = 0; brFallPc = 0; brReconvPc = 0;
    fetchValid = 0; fetchPc = 0;
  endtask

  // all tasks start and end at a negedge
  task automatic branch(logic [31:0] tk, logic [31:0] tgt, logic [31:0] fall, logic [31:0] rpc);
    brValid = 1; brTakenMask = tk; brTargetPc = tgt; brFallPc = fall; brReconvPc = rpc;
    @(negedge clk);
    clearIn();
  endtask

  task automatic fetch(logic [31:0] pc);
    fetchValid = 1; fetchPc = pc;
    @(negedge clk);
    clearIn();
  endtask

  task automatic expectState(string tag, logic [31:0] m, logic [31:0] pc);
    chk({tag, " mask"}, activeMask, m);
    chk({tag, " pc"}, nextPc, pc);
  endtask

  task automatic doReset();
    clearIn();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    expectState("R1 reset", ALL, RST_PC);
    chk("R1 ovf", {31'd0, ovfErr}, 32'd0);
  endtask

  task automatic testUniform();
    branch(ALL, 32'h200, 32'h204, 32'h300);
    expectState("R2 uniform taken", ALL, 32'h200);
    branch(32'h0, 32'h400, 32'h208, 32'h300);
    expectState("R3 uniform fall", ALL, 32'h208);
  endtask

  task automatic testSplit();
    branch(32'h0000_FFFF, 32'hA0, 32'hB0, 32'hC0);
    expectState("R5 split", 32'h0000_FFFF, 32'hA0);
    fetchPc = 32'hC0; fetchValid = 0;
    @(negedge clk);
    clearIn();
    expectState("R7 fetch not valid", 32'h0000_FFFF, 32'hA0);
    fetch(32'hC4);
    expectState("R7 no match", 32'h0000_FFFF, 32'hA0);
    fetch(32'hC0);
    expectState("R6 pop to fall path", 32'hFFFF_0000, 32'hB0);
    fetch(32'hC0);
    expectState("R6 pop to merge", ALL, 32'hC0);
    fetch(32'hC0);
    expectState("R7 bottom no pop", ALL, 32'hC0);
  endtask

  task automatic testIgnore();
    branch(32'h0000_00FF, 32'h500, 32'h510, 32'h520);
    expectState("R4 setup", 32'h0000_00FF, 32'h500);
    branch(32'hFFFF_FF00, 32'h600, 32'h504, 32'h700);
    expectState("R4 inactive taken ignored", 32'h0000_00FF, 32'h504);
    branch(32'hFFFF_FFFF, 32'h508, 32'h50C, 32'h700);
    expectState("R4 all active taken", 32'h0000_00FF, 32'h508);
    fetch(32'h520);
    expectState("R4 unwind 1", 32'hFFFF_FF00, 32'h510);
    fetch(32'h520);
    expectState("R4 unwind 2", ALL, 32'h520);
  endtask

  task automatic testNest();
    branch(32'h0000_FFFF, 32'h1000, 32'h2000, 32'h3000);
    branch(32'h0000_00FF, 32'h1100, 32'h1200, 32'h1300);
    expectState("R8 inner split", 32'h0000_00FF, 32'h1100);
    fetch(32'h3000);
    expectState("R8 outer rpc ignored inside", 32'h0000_00FF, 32'h1100);
    fetch(32'h1300);
    expectState("R8 inner fall", 32'h0000_FF00, 32'h1200);
    fetch(32'h1300);
    expectState("R8 inner merge", 32'h0000_FFFF, 32'h1300);
    fetch(32'h3000);
    expectState("R8 outer fall", 32'hFFFF_0000, 32'h2000);
    fetch(32'h3000);
    expectState("R8 outer merge", ALL, 32'h3000);
  endtask

  task automatic testSimul();
    branch(32'h0F0F_0F0F, 32'hA00, 32'hB00, 32'hC00);
    expectState("R10 setup", 32'h0F0F_0F0F, 32'hA00);
    fetchValid = 1; fetchPc = 32'hC00;
    brValid = 1; brTakenMask = 32'h0000_00FF;
    brTargetPc = 32'hD00; brFallPc = 32'hE00; brReconvPc = 32'hF00;
    @(negedge clk);
    clearIn();
    expectState("R10 pop then split", 32'h0000_00F0, 32'hD00);
    fetch(32'hF00);
    expectState("R10 second path", 32'hF0F0_F000, 32'hE00);
    fetch(32'hF00);
    expectState("R10 inner merge", 32'hF0F0_F0F0, 32'hF00);
    fetch(32'hC00);
    expectState("R10 outer merge", ALL, 32'hC00);
    branch(32'h0000_0F0F, 32'h1A0, 32'h1B0, 32'h1C0);
    fetchValid = 1; fetchPc = 32'h1C0;
    brValid = 1; brTakenMask = 32'h0000_0000;
    brTargetPc = 32'h1D0; brFallPc = 32'h1E0; brReconvPc = 32'h1F0;
    @(negedge clk);
    clearIn();
    expectState("R10 pop then uniform", 32'hFFFF_F0F0, 32'h1E0);
    fetch(32'h1C0);
    expectState("R10 uniform merge", ALL, 32'h1C0);
  endtask

  task automatic testOverflow();
    branch(32'h0000_FFFF, 32'h10, 32'h14, 32'h18);
    branch(32'h0000_00FF, 32'h20, 32'h24, 32'h28);
    branch(32'h0000_000F, 32'h30, 32'h34, 32'h38);
    expectState("R9 depth 7 used", 32'h0000_000F, 32'h30);
    chk("R9 no ovf yet", {31'd0, ovfErr}, 32'd0);
    branch(32'h0000_0003, 32'h40, 32'h44, 32'h48);
    expectState("R9 overflow no change", 32'h0000_000F, 32'h30);
    chk("R9 ovf set", {31'd0, ovfErr}, 32'd1);
    fetch(32'h38);
    expectState("R9 pop after ovf", 32'h0000_00F0, 32'h34);
    chk("R9 ovf sticky", {31'd0, ovfErr}, 32'd1);
    doReset();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0;
    clearIn();
    @(negedge clk);
    doReset();
    testUniform();
    testSplit();
    testIgnore();
    testNest();
    testSimul();
    testOverflow();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule